// File: doc/BRIEF.md
# Coprocessor debug halt controller

This block decides when a small coprocessor core stops for debugging and when it starts again. The core reports each instruction boundary with a one-cycle strobe. On that strobe it also gives the address of the opcode that would run next, and two flags for that opcode: it is the dedicated break opcode, or an external debug unit has tagged it. Stop requests that do not come from the opcode stream wait in latches until the next boundary. One kind is a forced request from the external debug unit. The other is a control-register write that sets the debug bit and its write-mask bit together.

When a stop is taken, `halt_o` goes high in the boundary cycle, so the next opcode never starts. The resume address is captured, and the debug status bit reads 1 from the following cycle. Software leaves debug mode by clearing the debug bit. The core then reloads the resume address if a thread is active, or goes idle if no thread is active. While halted, software can run one instruction at a time. When the device is secured, the block blocks register reads and writes from the bus and ignores single-step requests.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset `halt_o`, `dbg_stat_o`, `swbrk_o`, `resume_o` and `idle_o` are all 0.
- R2: A control write with `ctl_dbg_i`=1 and `ctl_dbg_mask_i`=1 while running is held pending. `dbg_stat_o` and `halt_o` stay 0 until the next boundary. In that boundary cycle `halt_o` is 1, and `dbg_stat_o` is 1 from the next cycle. A control write with the mask bit at 0 has no effect.
- R3: A boundary with `brk_op_i`=1 halts the core and captures `next_pc_i` (the break opcode's address) into `resume_pc_o`. `swbrk_o` pulses for exactly one cycle, in the cycle after the boundary.
- R4: A boundary with `tag_i`=1 asserts `halt_o` in that same cycle, so the tagged opcode never starts. It captures the tagged opcode's address as the resume address and does not pulse `swbrk_o`.
- R5: A `force_brk_i` pulse while running is held pending, and the core halts at the next boundary.
- R6: The tag flag takes precedence over the break opcode, which takes precedence over pending requests. When several are present at once, exactly one entry happens, and every pending request is cleared by that entry.
- R7: A control write with `ctl_dbg_i`=0 and `ctl_dbg_mask_i`=1 while halted leaves debug mode, and `dbg_stat_o` returns to 0. If `chan_id_i` is nonzero, `resume_o` pulses for one cycle with `resume_pc_o` valid. If `chan_id_i` is zero, `idle_o` pulses for one cycle instead.
- R8: A control write with `ctl_dbg_i`=0 and `ctl_dbg_mask_i`=1 while running clears any pending request, so the next boundary does not halt.
- R9: Register select encoding: 0 to 7 select R0 to R7, 8 selects the condition-code register, 9 selects the PC. While `secure_i`=1, `rf_rdata_o` is 0 and `rf_we_o` is 0 for selects 1 to 9, and select 0 passes through unchanged.
- R10: While `secure_i`=1, `step_req_i` has no effect: the core stays halted and `resume_o` does not pulse.
- R11: While halted and not secured, `step_req_i` pulses `resume_o` and drops `halt_o`. At the next boundary the block halts again with `resume_pc_o` equal to that boundary's `next_pc_i`, and `dbg_stat_o` stays 1 throughout.
- R12: While halted and not secured, a register write to select 9 loads `rf_wdata_i` into `resume_pc_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary strobe |
| next_pc_i | input | AW | Address of the opcode due to run next |
| brk_op_i | input | 1 | Next opcode is the break opcode |
| tag_i | input | 1 | Next opcode carries a debug tag |
| force_brk_i | input | 1 | Forced stop request from the external debug unit |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_dbg_i | input | 1 | Debug bit value being written |
| ctl_dbg_mask_i | input | 1 | Write-mask bit for the debug bit |
| chan_id_i | input | CW | Active thread channel, 0 when no thread is active |
| secure_i | input | 1 | Device is secured |
| step_req_i | input | 1 | Single-step request |
| rf_sel_i | input | SELW | Core register select for bus access |
| rf_we_i | input | 1 | Bus write to the selected core register |
| rf_wdata_i | input | DW | Bus write data |
| rf_rdata_i | input | DW | Read data from the core datapath |
| halt_o | output | 1 | Core must not start the next opcode |
| dbg_stat_o | output | 1 | Debug status bit as seen by software |
| resume_pc_o | output | AW | Address the core restarts from |
| resume_o | output | 1 | One-cycle pulse: reload PC from resume_pc_o and run |
| idle_o | output | 1 | One-cycle pulse: no thread is active, so the core goes idle |
| swbrk_o | output | 1 | One-cycle software break notice to the debug unit |
| rf_we_o | output | 1 | Gated register write strobe to the datapath |
| rf_rdata_o | output | DW | Gated register read data to the bus |

## Verification
The assertions assume that `boundary_i` is a single-cycle strobe. They also assume `brk_op_i`, `tag_i` and `next_pc_i` are meaningful only in a boundary cycle, and that the core raises no boundary while it is halted, except the one that ends a single step. The stimulus follows these rules. Flags are driven only together with a boundary, and every pulse input is cleared after one cycle. No boundary is issued while the block is halted unless a step is in progress. Control writes and register accesses are made one at a time, so that each result can be traced to a single cause.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_STEP} dbg_state_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_TAG, SRC_BRK, SRC_REQ} dbg_src_e;
  localparam int unsigned REQ_CTL = 0;
  localparam int unsigned REQ_FRC = 1;
  localparam int unsigned NUM_REQ = 2;
  localparam int unsigned SEL_FIRST_PROT = 1;
  localparam int unsigned SEL_PC = 9;
endpackage

// File: rtl/dbg_req_latch.sv
module dbg_req_latch #(
  parameter int unsigned NREQ = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] set_i,
  input  logic            clr_i,
  output logic [NREQ-1:0] pend_o
);
  logic [NREQ-1:0] pend_q;

  // clear beats a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else begin
      for (int i = 0; i < NREQ; i++) begin
        if (clr_i)         pend_q[i] <= 1'b0;
        else if (set_i[i]) pend_q[i] <= 1'b1;
      end
    end
  end

  assign pend_o = pend_q;

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pend_o == '0)); // R8
endmodule

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
  import dbg_halt_pkg::*;
(
  input  logic     arm_i,
  input  logic     tag_i,
  input  logic     brk_i,
  input  logic     pend_i,
  output logic     take_o,
  output dbg_src_e src_o
);
  always_comb begin
    src_o = SRC_NONE;
    if (arm_i) begin
      if (tag_i)       src_o = SRC_TAG;
      else if (brk_i)  src_o = SRC_BRK;
      else if (pend_i) src_o = SRC_REQ;
    end
    take_o = (src_o != SRC_NONE);
  end
endmodule

// File: rtl/dbg_sec_gate.sv
module dbg_sec_gate
  import dbg_halt_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned SELW = 4
) (
  input  logic            secure_i,
  input  logic [SELW-1:0] rf_sel_i,
  input  logic            rf_we_i,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [DW-1:0]   rf_rdata_o
);
  localparam logic [SELW-1:0] SelLo = SELW'(SEL_FIRST_PROT);
  localparam logic [SELW-1:0] SelHi = SELW'(SEL_PC);

  logic prot_sel, blocked;

  assign prot_sel   = (rf_sel_i >= SelLo) && (rf_sel_i <= SelHi);
  assign blocked    = secure_i && prot_sel;
  assign rf_we_o    = rf_we_i && !blocked;
  assign rf_rdata_o = blocked ? '0 : rf_rdata_i;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 7,
  parameter int unsigned SELW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            boundary_i,
  input  logic [AW-1:0]   next_pc_i,
  input  logic            brk_op_i,
  input  logic            tag_i,
  input  logic            force_brk_i,
  input  logic            ctl_we_i,
  input  logic            ctl_dbg_i,
  input  logic            ctl_dbg_mask_i,
  input  logic [CW-1:0]   chan_id_i,
  input  logic            secure_i,
  input  logic            step_req_i,
  input  logic [SELW-1:0] rf_sel_i,
  input  logic            rf_we_i,
  input  logic [DW-1:0]   rf_wdata_i,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            halt_o,
  output logic            dbg_stat_o,
  output logic [AW-1:0]   resume_pc_o,
  output logic            resume_o,
  output logic            idle_o,
  output logic            swbrk_o,
  output logic            rf_we_o,
  output logic [DW-1:0]   rf_rdata_o
);
  localparam logic [SELW-1:0] PcSel = SELW'(SEL_PC);

  dbg_state_e      state_q;
  dbg_src_e        src;
  logic [AW-1:0]   pc_q;
  logic            resume_q, idle_q, swbrk_q;
  logic            running, ctl_set, ctl_clr, take, step_end, pc_wr;
  logic [NUM_REQ-1:0] req_set, pend;

  assign running  = (state_q == ST_RUN);
  assign ctl_set  = ctl_we_i && ctl_dbg_mask_i && ctl_dbg_i;
  assign ctl_clr  = ctl_we_i && ctl_dbg_mask_i && !ctl_dbg_i;
  assign step_end = boundary_i && (state_q == ST_STEP);

  always_comb begin
    req_set          = '0;
    req_set[REQ_CTL] = ctl_set && running;
    req_set[REQ_FRC] = force_brk_i && running;
  end

  dbg_req_latch #(.NREQ(NUM_REQ)) u_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (req_set),
    .clr_i (take || ctl_clr),
    .pend_o(pend)
  );

  dbg_entry_arb u_arb (
    .arm_i (boundary_i && running),
    .tag_i (tag_i),
    .brk_i (brk_op_i),
    .pend_i(|pend),
    .take_o(take),
    .src_o (src)
  );

  dbg_sec_gate #(.DW(DW), .SELW(SELW)) u_gate (
    .secure_i  (secure_i),
    .rf_sel_i  (rf_sel_i),
    .rf_we_i   (rf_we_i),
    .rf_rdata_i(rf_rdata_i),
    .rf_we_o   (rf_we_o),
    .rf_rdata_o(rf_rdata_o)
  );

  assign pc_wr = rf_we_o && (rf_sel_i == PcSel) && (state_q == ST_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      pc_q     <= '0;
      resume_q <= 1'b0;
      idle_q   <= 1'b0;
      swbrk_q  <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      idle_q   <= 1'b0;
      swbrk_q  <= 1'b0;
      unique case (state_q)
        ST_RUN: if (take) begin
          state_q <= ST_HALT;
          pc_q    <= next_pc_i;
          swbrk_q <= (src == SRC_BRK);
        end
        ST_HALT: begin
          if (pc_wr) pc_q <= rf_wdata_i[AW-1:0];
          if (ctl_clr) begin
            state_q  <= ST_RUN;
            resume_q <= (chan_id_i != '0);
            idle_q   <= (chan_id_i == '0);
          end else if (step_req_i && !secure_i) begin
            state_q  <= ST_STEP;
            resume_q <= 1'b1;
          end
        end
        ST_STEP: begin
          if (ctl_clr) state_q <= ST_RUN;
          else if (step_end) begin
            state_q <= ST_HALT;
            pc_q    <= next_pc_i;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign halt_o      = (state_q == ST_HALT) || take || step_end;
  assign dbg_stat_o  = !running;
  assign resume_pc_o = pc_q;
  assign resume_o    = resume_q;
  assign idle_o      = idle_q;
  assign swbrk_o     = swbrk_q;

  AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbg_stat_o) |-> $past(boundary_i)); // R2
  AST_SWBRK_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swbrk_o |-> $rose(dbg_stat_o)); // R3
  AST_SWBRK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swbrk_o |=> !swbrk_o); // R3
  AST_TAG_NO_SWBRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && tag_i && running) |=> !swbrk_o); // R6
  AST_IDLE_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!dbg_stat_o && !resume_o)); // R7
  AST_SEC_PC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_HALT) && secure_i && rf_we_i && (rf_sel_i == PcSel)) |=> $stable(resume_pc_o)); // R9
  AST_SEC_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_HALT) && secure_i && step_req_i && !ctl_clr) |=> (halt_o && !resume_o)); // R10
  AST_STEP_REHALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_end && !ctl_clr) |=> (dbg_stat_o && resume_pc_o == $past(next_pc_i))); // R11
endmodule

// File: tb/dbg_halt_ctrl_test.sv
module dbg_halt_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int K_ENTER = 0, K_SWBRK = 1, K_RESUME = 2, K_IDLE = 3;

  typedef struct {
    int          kind;
    logic [15:0] pc;
    string       req;
  } ev_t;

  logic        clk_i = 0, rst_ni = 0;
  logic        boundary_i = 0, brk_op_i = 0, tag_i = 0, force_brk_i = 0;
  logic [15:0] next_pc_i = '0;
  logic        ctl_we_i = 0, ctl_dbg_i = 0, ctl_dbg_mask_i = 0;
  logic [6:0]  chan_id_i = '0;
  logic        secure_i = 0, step_req_i = 0;
  logic [3:0]  rf_sel_i = '0;
  logic        rf_we_i = 0;
  logic [15:0] rf_wdata_i = '0, rf_rdata_i = '0;
  logic        halt_o, dbg_stat_o, resume_o, idle_o, swbrk_o, rf_we_o;
  logic [15:0] resume_pc_o, rf_rdata_o;

  int   checks = 0, errors = 0;
  bit   done = 0;
  ev_t  ev_q[$];
  logic prev_stat = 0;

  dbg_halt_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic expect_ev(int kind, logic [15:0] pc, string req);
    ev_t e;
    e.kind = kind; e.pc = pc; e.req = req;
    ev_q.push_back(e);
  endtask

  task automatic see_ev(int kind, string name);
    ev_t e;
    if (ev_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL unexpected %s: actual=1 expected=0", name);
    end else begin
      e = ev_q.pop_front();
      check(e.req, {"event kind ", name}, kind, e.kind);
      if (kind == K_ENTER || kind == K_RESUME)
        check(e.req, {"event pc ", name}, resume_pc_o, e.pc);
    end
  endtask

  // monitor: compares output events against the expected queue
  always begin
    @(posedge clk_i); #1;
    if (rst_ni) begin
      if (dbg_stat_o && !prev_stat) see_ev(K_ENTER, "enter");
      if (swbrk_o)  see_ev(K_SWBRK, "swbrk");
      if (resume_o) see_ev(K_RESUME, "resume");
      if (idle_o)   see_ev(K_IDLE, "idle");
    end
    prev_stat = dbg_stat_o;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  task automatic release_pulses();
    boundary_i = 0; brk_op_i = 0; tag_i = 0; force_brk_i = 0;
    ctl_we_i = 0; step_req_i = 0; rf_we_i = 0;
  endtask

  task automatic next_cyc();
    @(negedge clk_i);
    release_pulses();
  endtask

  task automatic bnd(logic [15:0] pc, logic brk, logic tag);
    @(negedge clk_i);
    release_pulses();
    boundary_i = 1; next_pc_i = pc; brk_op_i = brk; tag_i = tag;
    #1;
  endtask

  task automatic ctl(logic dbg, logic mask);
    @(negedge clk_i);
    release_pulses();
    ctl_we_i = 1; ctl_dbg_i = dbg; ctl_dbg_mask_i = mask;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", "halt after reset", halt_o, 0);
    check("R1", "stat after reset", dbg_stat_o, 0);
    check("R1", "pulses after reset", {swbrk_o, resume_o, idle_o}, 0);
    rst_ni = 1;
    next_cyc();

    // R2: unmasked write ignored, masked write pending until boundary
    ctl(1, 0);
    bnd(16'h0080, 0, 0);
    check("R2", "halt with mask clear", halt_o, 0);
    ctl(1, 1);
    repeat (3) next_cyc();
    check("R2", "stat before boundary", dbg_stat_o, 0);
    check("R2", "halt before boundary", halt_o, 0);
    expect_ev(K_ENTER, 16'h0100, "R2");
    bnd(16'h0100, 0, 0);
    check("R2", "halt at boundary", halt_o, 1);
    next_cyc();
    check("R2", "stat after entry", dbg_stat_o, 1);
    chan_id_i = 7'd3;
    expect_ev(K_RESUME, 16'h0100, "R7");
    ctl(0, 1);
    next_cyc();
    check("R7", "stat after leave", dbg_stat_o, 0);

    // R3: break opcode
    expect_ev(K_ENTER, 16'h0200, "R3");
    expect_ev(K_SWBRK, 16'h0000, "R3");
    bnd(16'h0200, 1, 0);
    check("R3", "halt at break", halt_o, 1);
    next_cyc();
    check("R3", "swbrk pulse", swbrk_o, 1);
    next_cyc();
    check("R3", "swbrk one cycle", swbrk_o, 0);
    chan_id_i = '0;
    expect_ev(K_IDLE, 16'h0000, "R7");
    ctl(0, 1);
    next_cyc();
    check("R7", "idle pulse", idle_o, 1);

    // R4: tagged opcode
    expect_ev(K_ENTER, 16'h0300, "R4");
    bnd(16'h0300, 0, 1);
    check("R4", "halt before tagged", halt_o, 1);
    next_cyc();
    check("R4", "no swbrk on tag", swbrk_o, 0);
    chan_id_i = 7'd1;
    expect_ev(K_RESUME, 16'h0300, "R4");
    ctl(0, 1);
    next_cyc();

    // R5: forced request
    @(negedge clk_i); release_pulses(); force_brk_i = 1;
    repeat (2) next_cyc();
    check("R5", "no halt before boundary", dbg_stat_o, 0);
    expect_ev(K_ENTER, 16'h0400, "R5");
    bnd(16'h0400, 0, 0);
    check("R5", "halt at boundary", halt_o, 1);
    expect_ev(K_RESUME, 16'h0400, "R5");
    ctl(0, 1);
    next_cyc();

    // R6: tag beats break and pending force; single entry
    @(negedge clk_i); release_pulses(); force_brk_i = 1;
    expect_ev(K_ENTER, 16'h0500, "R6");
    bnd(16'h0500, 1, 1);
    check("R6", "halt on tag+brk", halt_o, 1);
    next_cyc();
    check("R6", "no swbrk when tag wins", swbrk_o, 0);
    expect_ev(K_RESUME, 16'h0500, "R6");
    ctl(0, 1);
    next_cyc();
    bnd(16'h0510, 0, 0);
    check("R6", "pending cleared by entry", halt_o, 0);
    ctl(1, 1);
    expect_ev(K_ENTER, 16'h0600, "R6");
    expect_ev(K_SWBRK, 16'h0000, "R6");
    bnd(16'h0600, 1, 0);
    next_cyc();
    chan_id_i = '0;
    expect_ev(K_IDLE, 16'h0000, "R6");
    ctl(0, 1);
    next_cyc();
    bnd(16'h0610, 0, 0);
    check("R6", "write request cleared by entry", halt_o, 0);

    // R8: clear while running drops pending
    ctl(1, 1);
    ctl(0, 1);
    bnd(16'h0680, 0, 0);
    check("R8", "halt after clear", halt_o, 0);
    next_cyc();
    check("R8", "stat after clear", dbg_stat_o, 0);

    // R12 / R11: PC write, then single step
    expect_ev(K_ENTER, 16'h0700, "R11");
    bnd(16'h0700, 0, 1);
    @(negedge clk_i); release_pulses();
    rf_sel_i = 4'd9; rf_we_i = 1; rf_wdata_i = 16'h0720; #1;
    check("R12", "pc write passes", rf_we_o, 1);
    next_cyc();
    check("R12", "resume pc loaded", resume_pc_o, 16'h0720);
    expect_ev(K_RESUME, 16'h0720, "R11");
    @(negedge clk_i); release_pulses(); step_req_i = 1;
    next_cyc();
    check("R11", "halt released for step", halt_o, 0);
    check("R11", "stat held in step", dbg_stat_o, 1);
    bnd(16'h0724, 0, 0);
    check("R11", "halt after one instr", halt_o, 1);
    next_cyc();
    check("R11", "pc after step", resume_pc_o, 16'h0724);
    check("R11", "stat after step", dbg_stat_o, 1);

    // R9: secured register access
    secure_i = 1; rf_rdata_i = 16'h1234;
    @(negedge clk_i); release_pulses();
    rf_sel_i = 4'd9; rf_we_i = 1; rf_wdata_i = 16'h0BAD; #1;
    check("R9", "pc write blocked", rf_we_o, 0);
    check("R9", "pc read zero", rf_rdata_o, 0);
    next_cyc();
    check("R9", "resume pc unchanged", resume_pc_o, 16'h0724);
    rf_sel_i = 4'd0; #1;
    check("R9", "R0 read passes", rf_rdata_o, 16'h1234);
    rf_sel_i = 4'd5; #1;
    check("R9", "R5 read zero", rf_rdata_o, 0);
    rf_sel_i = 4'd8; rf_we_i = 1; #1;
    check("R9", "ccr read zero", rf_rdata_o, 0);
    check("R9", "ccr write blocked", rf_we_o, 0);
    next_cyc();

    // R10: secured step ignored
    @(negedge clk_i); release_pulses(); step_req_i = 1;
    next_cyc();
    check("R10", "halt kept", halt_o, 1);
    check("R10", "no resume", resume_o, 0);
    secure_i = 0; rf_sel_i = 4'd5; #1;
    check("R9", "R5 read unsecured", rf_rdata_o, 16'h1234);
    chan_id_i = 7'd2;
    expect_ev(K_RESUME, 16'h0724, "R7");
    ctl(0, 1);
    repeat (3) next_cyc();
    check("R7", "all expected events seen", ev_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule